// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Message Receiver

This block listens to a single-wire vehicle bus that encodes information in the width of its active and passive phases. It gets an already synchronized copy of the bus level (1 = active, 0 = passive) and a timing tick that advances its width counter. Every phase is measured in ticks. When a phase ends it is classified as a frame start, a data bit or a bad symbol. Long passive stretches are recognized as end of data or end of frame as soon as they reach their thresholds. A long active stretch is recognized as a break at its threshold.

Bits are assembled most significant first into bytes. Each finished byte is placed in one holding register, and a full flag is raised alongside it. A CPU reads the byte and pulses a read strobe to drop the flag. No queue stands behind the register, so an unserviced byte is replaced by the next one without any warning. The message CRC is checked once the end of data is seen. Bytes answered by another node after the end of data, known as an in-frame response, are delivered through the same register. A symbol error or a break abandons the frame at once. After that, the receiver ignores the bus until it has been idle for a whole end-of-frame time.

Top module: `vpw_msg_rx`

## Requirements
- R1: An active phase that ends with a width between SOF_MIN and SOF_MAX ticks, while the receiver is idle, starts a frame. Any other active phase seen while idle is ignored.
- R2: Data bits follow the pulse-width rule. A passive short phase (SHORT_MIN..SHORT_MAX) is 1 and a passive long phase (LONG_MIN..LONG_MAX) is 0. An active short phase is 0 and an active long phase is 1. The first bit after the frame start is passive. Bits are taken MSB first. Every eighth bit writes the byte to `rx_data` and sets `rx_full`.
- R3: A new byte overwrites an unread one and raises no overrun indication. After an unread message, `rx_data` holds the last byte, which is the CRC byte.
- R4: A `rd_strobe` pulse clears `rx_full` on the next cycle, unless a byte completes in that same cycle.
- R5: The CRC is CRC-8 with polynomial 0x1D, initial value 0xFF, taken over every message byte including the received CRC byte (sent as the complement). A valid message leaves the residue 0xC4. A mismatch is posted only when the passive phase reaches EOD_MIN ticks. In-frame response bytes are not covered by the CRC.
- R6: During a frame, any of the following is an invalid symbol: a phase outside every window, a frame-start width inside a frame, or an end of data that falls mid-byte or before any byte. The status shows it within two cycles of the phase end, and the partial byte never reaches `rx_data`.
- R7: After an invalid symbol or a break, frame starts are ignored until the bus has stayed passive for EOF_MIN ticks.
- R8: An active phase that reaches BRK_MIN ticks posts the break status before the phase ends, in any state other than lock-out.
- R9: After end of data, an active normalization bit followed by bits forms in-frame response bytes. These are written to `rx_data` and post the in-frame-response status before the end-of-frame status appears.
- R10: `status_code` shows one code: 6 break, 5 invalid symbol, 4 CRC error, 3 end of frame, 2 in-frame response received, 1 receive data full, 0 none. The highest-priority pending event wins. A new frame start clears every event except receive-data-full.
- R11: After reset `status_code` is 0, `rx_full` is 0 and `rx_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Timing tick; the width counter advances once per tick |
| bus_in | input | 1 | Synchronized bus level, 1 = active |
| rd_strobe | input | 1 | CPU read of the data register; clears the full flag |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | A byte is waiting in `rx_data` |
| status_code | output | 3 | Highest-priority pending receive event |

## Verification
The bench builds the receiver with short windows: short 4..11 and long 12..19 ticks, frame start 20..29, end of data at 20, and both end of frame and break at 30. The tick is held high, so a width is simply a count of clock cycles. At this scale every single-byte message value can be sent (256 frames). The bench also sweeps every frame-start width from 1 to 35 and every first-bit passive width from 1 to 19. Together these sweeps cover each window edge, the break threshold, and the CRC residue for all byte values, within a short run.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

  typedef enum logic [2:0] {
    ST_NONE = 3'd0,
    ST_RDF  = 3'd1,
    ST_IFR  = 3'd2,
    ST_EOF  = 3'd3,
    ST_CRC  = 3'd4,
    ST_INV  = 3'd5,
    ST_BRK  = 3'd6
  } stat_code_e;

  typedef enum logic [1:0] {
    PK_BIT,
    PK_SOF,
    PK_GAP,
    PK_BAD
  } pulse_kind_e;

  typedef struct packed {
    pulse_kind_e kind;
    logic        bitval;
  } pulse_class_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MSG,
    S_EOD,
    S_IFR,
    S_IFR_EOD,
    S_LOCK
  } rx_state_e;

  localparam logic [7:0] CRC_INIT    = 8'hFF;
  localparam logic [7:0] CRC_POLY    = 8'h1D;
  localparam logic [7:0] CRC_RESIDUE = 8'hC4;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic d);
    logic fb;
    fb = c[7] ^ d;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

endpackage

// File: rtl/vpw_pulse_meas.sv
module vpw_pulse_meas #(
  parameter int CW      = 9,
  parameter int EOD_MIN = 164,
  parameter int EOF_MIN = 240,
  parameter int BRK_MIN = 240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_in,
  output logic          pulse_vld,
  output logic          pulse_lvl,
  output logic [CW-1:0] pulse_w,
  output logic          eod_hit,
  output logic          eof_hit,
  output logic          brk_hit
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] T_EOD   = CW'(EOD_MIN);
  localparam logic [CW-1:0] T_EOF   = CW'(EOF_MIN);
  localparam logic [CW-1:0] T_BRK   = CW'(BRK_MIN);

  logic          bus_q;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          edge_c, adv;
  logic          eod_d, eof_d, brk_d;

  always_comb begin
    edge_c  = bus_in ^ bus_q;
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    if (edge_c) begin
      cnt_d = tick ? CW'(1) : '0;
    end else if (tick) begin
      cnt_d = cnt_inc;
    end else begin
      cnt_d = cnt_q;
    end
    adv   = tick && !edge_c && (cnt_q != CNT_MAX);
    eod_d = adv && !bus_q && (cnt_inc == T_EOD);
    eof_d = adv && !bus_q && (cnt_inc == T_EOF);
    brk_d = adv &&  bus_q && (cnt_inc == T_BRK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q     <= 1'b0;
      cnt_q     <= '0;
      pulse_vld <= 1'b0;
      pulse_lvl <= 1'b0;
      pulse_w   <= '0;
      eod_hit   <= 1'b0;
      eof_hit   <= 1'b0;
      brk_hit   <= 1'b0;
    end else begin
      bus_q     <= bus_in;
      cnt_q     <= cnt_d;
      pulse_vld <= edge_c;
      if (edge_c) begin
        pulse_lvl <= bus_q;
        pulse_w   <= cnt_q;
      end
      eod_hit   <= eod_d;
      eof_hit   <= eof_d;
      brk_hit   <= brk_d;
    end
  end

endmodule

// File: rtl/vpw_sym_class.sv
module vpw_sym_class
  import vpw_rx_pkg::*;
#(
  parameter int CW        = 9,
  parameter int SHORT_MIN = 34,
  parameter int SHORT_MAX = 96,
  parameter int LONG_MIN  = 97,
  parameter int LONG_MAX  = 163,
  parameter int SOF_MIN   = 164,
  parameter int SOF_MAX   = 239,
  parameter int EOD_MIN   = 164
) (
  input  logic          lvl,
  input  logic [CW-1:0] width,
  output pulse_class_t  cls
);

  localparam logic [CW-1:0] W_SMIN = CW'(SHORT_MIN);
  localparam logic [CW-1:0] W_SMAX = CW'(SHORT_MAX);
  localparam logic [CW-1:0] W_LMIN = CW'(LONG_MIN);
  localparam logic [CW-1:0] W_LMAX = CW'(LONG_MAX);
  localparam logic [CW-1:0] W_FMIN = CW'(SOF_MIN);
  localparam logic [CW-1:0] W_FMAX = CW'(SOF_MAX);
  localparam logic [CW-1:0] W_EOD  = CW'(EOD_MIN);

  logic is_short, is_long, is_sof;

  always_comb begin
    is_short = (width >= W_SMIN) && (width <= W_SMAX);
    is_long  = (width >= W_LMIN) && (width <= W_LMAX);
    is_sof   = (width >= W_FMIN) && (width <= W_FMAX);
    cls.kind   = PK_BAD;
    cls.bitval = 1'b0;
    if (is_short || is_long) begin
      cls.kind   = PK_BIT;
      cls.bitval = lvl ? is_long : is_short;
    end else if (lvl && is_sof) begin
      cls.kind = PK_SOF;
    end else if (!lvl && (width >= W_EOD)) begin
      cls.kind = PK_GAP;
    end
  end

endmodule

// File: rtl/vpw_crc8.sv
module vpw_crc8
  import vpw_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       en,
  input  logic       bit_in,
  output logic [7:0] crc
);

  logic [7:0] crc_d;

  always_comb begin
    crc_d = crc;
    if (init) begin
      crc_d = CRC_INIT;
    end else if (en) begin
      crc_d = crc8_step(crc, bit_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= CRC_INIT;
    end else if (init || en) begin
      crc <= crc_d;
    end
  end

endmodule

// File: rtl/vpw_rx_ctrl.sv
module vpw_rx_ctrl
  import vpw_rx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pulse_vld,
  input  logic         pulse_lvl,
  input  pulse_class_t cls,
  input  logic         eod_hit,
  input  logic         eof_hit,
  input  logic         brk_hit,
  input  logic         rd_strobe,
  input  logic [7:0]   crc_val,
  output logic         crc_init,
  output logic         crc_en,
  output logic         crc_bit,
  output logic         byte_wr,
  output logic         lock_st,
  output logic [7:0]   rx_data,
  output logic         rx_full,
  output logic [2:0]   status_code
);

  rx_state_e  st_q, st_d;
  logic [6:0] sh_q, sh_d;
  logic [2:0] bc_q, bc_d;
  logic       got_q, got_d;
  logic [7:0] data_d;
  logic       rdf_d;
  logic       brk_q, brk_d, inv_q, inv_d, crc_q, crc_d;
  logic       eof_q, eof_d, ifr_q, ifr_d;
  logic       in_frame;

  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    bc_d     = bc_q;
    got_d    = got_q;
    data_d   = rx_data;
    rdf_d    = rx_full;
    brk_d    = brk_q;
    inv_d    = inv_q;
    crc_d    = crc_q;
    eof_d    = eof_q;
    ifr_d    = ifr_q;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    crc_bit  = 1'b0;
    byte_wr  = 1'b0;
    in_frame = (st_q == S_MSG) || (st_q == S_IFR);

    if (rd_strobe) rdf_d = 1'b0;

    if (brk_hit && st_q != S_LOCK) begin
      brk_d = 1'b1;
      st_d  = S_LOCK;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (pulse_vld && pulse_lvl && cls.kind == PK_SOF) begin
            st_d     = S_MSG;
            bc_d     = 3'd0;
            got_d    = 1'b0;
            crc_init = 1'b1;
            brk_d    = 1'b0;
            inv_d    = 1'b0;
            crc_d    = 1'b0;
            eof_d    = 1'b0;
            ifr_d    = 1'b0;
          end
        end
        S_MSG, S_IFR: begin
          if (pulse_vld) begin
            if (cls.kind == PK_BIT) begin
              crc_en  = (st_q == S_MSG);
              crc_bit = cls.bitval;
              if (bc_q == 3'd7) begin
                byte_wr = 1'b1;
                data_d  = {sh_q, cls.bitval};
                rdf_d   = 1'b1;
                got_d   = 1'b1;
                bc_d    = 3'd0;
                if (st_q == S_IFR) ifr_d = 1'b1;
              end else begin
                sh_d = {sh_q[5:0], cls.bitval};
                bc_d = bc_q + 3'd1;
              end
            end else begin
              inv_d = 1'b1;
              st_d  = S_LOCK;
            end
          end else if (eod_hit) begin
            if (bc_q != 3'd0 || !got_q) begin
              inv_d = 1'b1;
              st_d  = S_LOCK;
            end else if (st_q == S_MSG) begin
              if (crc_val != CRC_RESIDUE) crc_d = 1'b1;
              st_d = S_EOD;
            end else begin
              st_d = S_IFR_EOD;
            end
          end
        end
        S_EOD: begin
          if (eof_hit) begin
            eof_d = 1'b1;
            st_d  = S_IDLE;
          end else if (pulse_vld && pulse_lvl) begin
            if (cls.kind == PK_BIT) begin
              st_d  = S_IFR;
              bc_d  = 3'd0;
              got_d = 1'b0;
            end else begin
              inv_d = 1'b1;
              st_d  = S_LOCK;
            end
          end
        end
        S_IFR_EOD: begin
          if (eof_hit) begin
            eof_d = 1'b1;
            st_d  = S_IDLE;
          end else if (pulse_vld && pulse_lvl) begin
            inv_d = 1'b1;
            st_d  = S_LOCK;
          end
        end
        S_LOCK: begin
          if (eof_hit) st_d = S_IDLE;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sh_q    <= '0;
      bc_q    <= '0;
      got_q   <= 1'b0;
      rx_data <= '0;
      rx_full <= 1'b0;
      brk_q   <= 1'b0;
      inv_q   <= 1'b0;
      crc_q   <= 1'b0;
      eof_q   <= 1'b0;
      ifr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      if (in_frame || st_d != st_q) begin
        sh_q  <= sh_d;
        bc_q  <= bc_d;
        got_q <= got_d;
      end
      if (byte_wr) rx_data <= data_d;
      rx_full <= rdf_d;
      brk_q   <= brk_d;
      inv_q   <= inv_d;
      crc_q   <= crc_d;
      eof_q   <= eof_d;
      ifr_q   <= ifr_d;
    end
  end

  always_comb begin
    lock_st = (st_q == S_LOCK);
    if (brk_q)        status_code = ST_BRK;
    else if (inv_q)   status_code = ST_INV;
    else if (crc_q)   status_code = ST_CRC;
    else if (eof_q)   status_code = ST_EOF;
    else if (ifr_q)   status_code = ST_IFR;
    else if (rx_full) status_code = ST_RDF;
    else              status_code = ST_NONE;
  end

endmodule

// File: rtl/vpw_msg_rx.sv
module vpw_msg_rx
  import vpw_rx_pkg::*;
#(
  parameter int SHORT_MIN = 34,
  parameter int SHORT_MAX = 96,
  parameter int LONG_MIN  = 97,
  parameter int LONG_MAX  = 163,
  parameter int SOF_MIN   = 164,
  parameter int SOF_MAX   = 239,
  parameter int EOD_MIN   = 164,
  parameter int EOF_MIN   = 240,
  parameter int BRK_MIN   = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bus_in,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic [2:0] status_code
);

  localparam int TOP_W = (EOF_MIN > BRK_MIN) ? EOF_MIN : BRK_MIN;
  localparam int CW    = $clog2(TOP_W + 2) + 1;

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic          pulse_vld, pulse_lvl;
  logic [CW-1:0] pulse_w;
  logic          eod_hit, eof_hit, brk_hit;
  pulse_class_t  cls;
  logic          crc_init, crc_en, crc_bit;
  logic [7:0]    crc_val;
  logic          byte_wr, lock_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  vpw_pulse_meas #(
    .CW(CW), .EOD_MIN(EOD_MIN), .EOF_MIN(EOF_MIN), .BRK_MIN(BRK_MIN)
  ) u_meas (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .bus_in(bus_in),
    .pulse_vld(pulse_vld), .pulse_lvl(pulse_lvl), .pulse_w(pulse_w),
    .eod_hit(eod_hit), .eof_hit(eof_hit), .brk_hit(brk_hit)
  );

  vpw_sym_class #(
    .CW(CW), .SHORT_MIN(SHORT_MIN), .SHORT_MAX(SHORT_MAX),
    .LONG_MIN(LONG_MIN), .LONG_MAX(LONG_MAX),
    .SOF_MIN(SOF_MIN), .SOF_MAX(SOF_MAX), .EOD_MIN(EOD_MIN)
  ) u_cls (
    .lvl(pulse_lvl), .width(pulse_w), .cls(cls)
  );

  vpw_crc8 u_crc (
    .clk(clk), .rst_n(rst_sync_n), .init(crc_init), .en(crc_en),
    .bit_in(crc_bit), .crc(crc_val)
  );

  vpw_rx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .pulse_vld(pulse_vld), .pulse_lvl(pulse_lvl), .cls(cls),
    .eod_hit(eod_hit), .eof_hit(eof_hit), .brk_hit(brk_hit),
    .rd_strobe(rd_strobe), .crc_val(crc_val),
    .crc_init(crc_init), .crc_en(crc_en), .crc_bit(crc_bit),
    .byte_wr(byte_wr), .lock_st(lock_st),
    .rx_data(rx_data), .rx_full(rx_full), .status_code(status_code)
  );

endmodule

// File: rtl/vpw_msg_rx_chk.sv
module vpw_msg_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic       rx_full,
  input logic [2:0] status_code,
  input logic       byte_wr,
  input logic       lock_st,
  input logic       eod_hit,
  input logic       brk_hit,
  input logic       pulse_vld
);

  AST_RD_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !byte_wr) |=> !rx_full); // R4

  AST_NO_BYTE_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_st && !rx_full) |=> !rx_full); // R7

  AST_CRC_ONLY_AT_EOD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_code == 3'd4 && $past(status_code) != 3'd4) |-> $past(eod_hit)); // R5

  AST_INV_AT_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_code == 3'd5 && $past(status_code) != 3'd5) |-> $past(pulse_vld || eod_hit)); // R6

  AST_BRK_AT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_code == 3'd6 && $past(status_code) != 3'd6) |-> $past(brk_hit)); // R8

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status_code != 3'd7); // R10

endmodule

bind vpw_msg_rx vpw_msg_rx_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rd_strobe(rd_strobe), .rx_full(rx_full),
  .status_code(status_code), .byte_wr(byte_wr), .lock_st(lock_st),
  .eod_hit(eod_hit), .brk_hit(brk_hit), .pulse_vld(pulse_vld)
);

// File: tb/sim_vpw_msg_rx.sv
`timescale 1ns/1ps
module sim_vpw_msg_rx;

  localparam int W_SHORT = 8;
  localparam int W_LONG  = 16;
  localparam int W_SOF   = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       bus_in = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full;
  logic [2:0] status_code;

  int n_chk = 0;
  int n_err = 0;
  logic       lv;
  int         ovr_w = 0;
  logic [7:0] msg [0:7];

  always #10 clk = ~clk;

  vpw_msg_rx #(
    .SHORT_MIN(4), .SHORT_MAX(11), .LONG_MIN(12), .LONG_MAX(19),
    .SOF_MIN(20), .SOF_MAX(29), .EOD_MIN(20), .EOF_MIN(30), .BRK_MIN(30)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_in(bus_in),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
    .status_code(status_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drv(input logic l, input int n);
    bus_in = l;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    bus_in = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[7] ^ msg[i][b];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
      end
    end
    return ~c;
  endfunction

  function automatic int bit_w(input logic l, input logic b);
    if (l) return b ? W_LONG : W_SHORT;
    return b ? W_SHORT : W_LONG;
  endfunction

  task automatic send_byte(input logic [7:0] v);
    for (int b = 7; b >= 0; b--) begin
      drv(lv, bit_w(lv, v[b]));
      lv = ~lv;
    end
  endtask

  // frame start, n data bytes from msg plus CRC byte; no end-of-data
  task automatic send_frame(input int n, input logic corrupt, input logic rd_mid);
    msg[n] = ref_crc(n) ^ {7'd0, corrupt};
    drv(1'b1, W_SOF);
    lv = 1'b0;
    for (int k = 0; k < (n + 1) * 8; k++) begin
      logic b;
      int   w;
      b = msg[k / 8][7 - (k % 8)];
      w = bit_w(lv, b);
      if (k == 0 && ovr_w != 0) w = ovr_w;
      if (rd_mid && k > 0 && (k % 8) == 0) begin
        drv(lv, 4);
        chk("R2 mid-frame byte", rx_data, msg[k / 8 - 1]);
        chk("R10 data-full code", status_code, 1);
        do_read();
        @(negedge clk);
        chk("R4 read clears full", rx_full, 0);
        drv(lv, w - 6);
      end else begin
        drv(lv, w);
      end
      lv = ~lv;
    end
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    do_reset();
    // R11 reset state
    chk("R11 status", status_code, 0);
    chk("R11 full", rx_full, 0);
    chk("R11 data", rx_data, 0);

    // R2/R4 multi-byte frame read byte by byte
    msg[0] = 8'hA5; msg[1] = 8'h0F; msg[2] = 8'hC3;
    send_frame(3, 1'b0, 1'b1);
    drv(1'b0, 24);
    chk("R5 good CRC no error at EOD", status_code, 1);
    drv(1'b0, 12);
    chk("R10 end-of-frame code", status_code, 3);
    chk("R2 last byte", rx_data, msg[3]);
    do_read();
    chk("R4 full cleared", rx_full, 0);

    // R3 exhaustive single-byte frames, never read
    for (int v = 0; v < 256; v++) begin
      msg[0] = v[7:0];
      send_frame(1, 1'b0, 1'b0);
      drv(1'b0, 24);
      chk("R5 residue per value", status_code, 1);
      drv(1'b0, 12);
      chk("R10 eof per value", status_code, 3);
      chk("R3 CRC byte left", rx_data, msg[1]);
    end

    // R3 unread multi-byte: no overrun indication, CRC byte remains
    msg[0] = 8'h11; msg[1] = 8'h22; msg[2] = 8'h33; msg[3] = 8'h44;
    send_frame(4, 1'b0, 1'b0);
    drv(1'b0, 36);
    chk("R3 overwrite silent", status_code, 3);
    chk("R3 last byte kept", rx_data, msg[4]);
    chk("R3 full", rx_full, 1);

    // R5 corrupted CRC
    msg[0] = 8'h12; msg[1] = 8'h34;
    send_frame(2, 1'b1, 1'b0);
    drv(1'b0, 5);
    chk("R5 no CRC error before EOD", status_code, 1);
    drv(1'b0, 19);
    chk("R5 CRC error at EOD", status_code, 4);
    drv(1'b0, 12);
    chk("R10 CRC error over eof", status_code, 4);
    chk("R3 bad CRC byte in reg", rx_data, msg[2]);
    do_read();

    // R6 mid-byte invalid symbol, then R7 lock-out
    prev = rx_data;
    drv(1'b1, W_SOF);
    lv = 1'b0;
    drv(1'b0, bit_w(1'b0, 1'b1));
    drv(1'b1, bit_w(1'b1, 1'b0));
    drv(1'b0, bit_w(1'b0, 1'b1));
    drv(1'b1, 2);
    drv(1'b0, 3);
    chk("R6 invalid posted now", status_code, 5);
    chk("R6 partial byte dropped", rx_data, prev);
    chk("R6 no full", rx_full, 0);
    drv(1'b0, 10);
    msg[0] = 8'h5A;
    send_frame(1, 1'b0, 1'b0);
    drv(1'b0, 36);
    chk("R7 frame ignored in lock", status_code, 5);
    chk("R7 no byte in lock", rx_full, 0);
    msg[0] = 8'h3C;
    send_frame(1, 1'b0, 1'b0);
    drv(1'b0, 36);
    chk("R7 accepted after idle", status_code, 3);
    chk("R7 data after idle", rx_data, msg[1]);
    do_read();

    // R8 break
    drv(1'b1, 34);
    chk("R8 break while active", status_code, 6);
    drv(1'b0, 40);
    msg[0] = 8'h77;
    send_frame(1, 1'b0, 1'b0);
    drv(1'b0, 36);
    chk("R8 receive after break idle", status_code, 3);
    do_read();

    // R9 in-frame response
    msg[0] = 8'h61;
    send_frame(1, 1'b0, 1'b0);
    drv(1'b0, 24);
    do_read();
    drv(1'b1, W_SHORT);
    lv = 1'b0;
    send_byte(8'hB4);
    drv(1'b0, 24);
    chk("R9 IFR before EOF", status_code, 2);
    chk("R9 IFR byte", rx_data, 8'hB4);
    drv(1'b0, 12);
    chk("R9 EOF after IFR", status_code, 3);

    // R1/R8 sweep of frame-start widths
    for (int w = 1; w <= 35; w++) begin
      int exp_c;
      do_reset();
      msg[0] = 8'h96;
      msg[1] = ref_crc(1);
      drv(1'b1, w);
      lv = 1'b0;
      send_byte(msg[0]);
      send_byte(msg[1]);
      drv(1'b0, 36);
      exp_c = (w >= 30) ? 6 : ((w >= 20) ? 3 : 0);
      chk("R1 start width sweep", status_code, exp_c);
      chk("R1 start width full", rx_full, (w >= 20 && w < 30) ? 1 : 0);
    end

    // R2/R6 sweep of the first passive bit width
    for (int w = 1; w <= 19; w++) begin
      do_reset();
      msg[0] = {(w >= 12) ? 1'b0 : 1'b1, 7'h2B};
      ovr_w = w;
      send_frame(1, 1'b0, 1'b0);
      ovr_w = 0;
      drv(1'b0, 36);
      if (w < 4) begin
        chk("R6 short bit invalid", status_code, 5);
      end else begin
        chk("R2 bit width sweep", status_code, 3);
        chk("R2 bit value sweep", rx_data, msg[1]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule